// File: doc/BRIEF.md
# Serially Programmed Direct Digital Synthesizer

This block generates a digital waveform code from a 28-bit phase accumulator that advances by a programmable tuning word on every master clock. All programming arrives over a write-only, three-wire serial port: chip select low frames a transfer, the serial clock strobes data in, and each accepted frame updates one of five holding registers. These are a control word, two frequency tuning words and two phase offsets.

The control word picks the active tuning word and the active phase offset. It also selects sine or triangle output, turns the square output on or off, and can hold the accumulator at zero. Tuning words can be loaded as a pair of 14-bit frames that take effect together, or one half at a time. The serial pins are sampled in the master clock domain, so every register update lands in a single master clock cycle. The accumulator therefore never adds a tuning word that is only partly written.

Top module: `dds_serial_synth`

## Requirements
- R1: While rst_n is low, wave_out is 0 and sq_out is 0. Reset leaves both tuning words and both phase offsets at zero and the control word with only its hold bit (bit 8) set.
- R2: A frame is the data sampled on sdi at each rising sclk edge while cs_n is low, most significant bit first. It is applied when cs_n rises. A frame of any length other than 16 bits is discarded with no effect.
- R3: Frame bits [15:14] pick the target: 00 is the control word (bits [13:0]), 01 is tuning word 0 and 10 is tuning word 1 (data in bits [13:0]). 11 writes bits [11:0] to phase offset 0 when bit 13 is 0, or to phase offset 1 when bit 13 is 1.
- R4: With control bit 13 set, a tuning-word frame pair to the same target loads the lower 14 bits (first frame) and the upper 14 bits (second frame). The word changes only on the second frame. A lone first frame changes nothing, and any control-word write cancels a half-finished pair.
- R5: With control bit 13 clear, each tuning-word frame writes one half directly: the upper 14 bits when control bit 12 is 1, the lower 14 bits when it is 0.
- R6: Each master clock the accumulator adds tuning word 1 if control bit 11 is 1, else tuning word 0. Its most significant bit therefore has a period of 2^28 / word cycles.
- R7: The 12-bit phase value is the top 12 accumulator bits plus phase offset 1 if control bit 10 is 1, else phase offset 0 (modulo 4096).
- R8: While control bit 8 is set, the accumulator stays at zero, so wave_out is constant at the code for the phase offset alone and the square source stays low.
- R9: With control bit 1 clear, wave_out is a signed sine code computed from the phase value p. Let i = p[9:2], or 255 - p[9:2] when p[10] is 1. Then a = (i * (512 - i)) >> 7, and wave_out = a when p[11] is 0 and -a when it is 1.
- R10: With control bit 1 set, wave_out is the triangle code 2u - 511, where u = p[10:2] when p[11] is 0 and u = ~p[10:2] (9 bits) when p[11] is 1.
- R11: sq_out is 0 when control bit 5 is 0. When bit 5 is 1, sq_out follows the accumulator MSB if control bit 3 is 1, or toggles on each rising edge of that MSB (half frequency) if bit 3 is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock; accumulator and all registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, data taken on its rising edge |
| cs_n | input | 1 | Active-low frame select, frame applied on its rising edge |
| sdi | input | 1 | Serial data, most significant bit first |
| wave_out | output | 10 | Signed sine or triangle code |
| sq_out | output | 1 | Square output from the accumulator MSB |

## Verification
The hardest state to reach from the pins is the tuning-word pairing logic caught mid-pair. The bench leaves a lone first half pending and shows that the running frequency does not change. It then writes the control word and sends a fresh pair that would decode wrongly if the stale half were still held. The tuning word is observed only through the square output period, measured edge to edge in master clocks using power-of-two words so each period is exact. Waveform codes are checked with a zero tuning word, so the phase value equals the phase offset and each output is a fixed function of one programmed number.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam int ACC_W   = 28;
  localparam int PH_W    = 12;
  localparam int OUT_W   = 10;
  localparam int FRAME_W = 16;
  localparam int HALF_W  = ACC_W / 2;

  typedef struct packed {
    logic pair_mode;   // bit 13
    logic upper_sel;   // bit 12
    logic fsel;        // bit 11
    logic psel;        // bit 10
    logic hold;        // bit 8
    logic sq_en;       // bit 5
    logic sq_undiv;    // bit 3
    logic tri_mode;    // bit 1
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{pair_mode: 1'b0, upper_sel: 1'b0, fsel: 1'b0,
                                   psel: 1'b0, hold: 1'b1, sq_en: 1'b0,
                                   sq_undiv: 1'b0, tri_mode: 1'b0};
endpackage

// File: rtl/dds_serial_rx.sv
module dds_serial_rx #(
  parameter int FRAME_W = dds_pkg::FRAME_W
) (
  input  logic               mclk,
  input  logic               rst_n,
  input  logic               sclk,
  input  logic               cs_n,
  input  logic               sdi,
  output logic               frame_vld,
  output logic [FRAME_W-1:0] frame_data
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic [2:0] sclk_q, cs_q;
  logic [1:0] sdi_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic vld_q, vld_d;
  logic sclk_rise, cs_rise, cs_fall, cs_low;

  assign sclk_rise = sclk_q[1] & ~sclk_q[2];
  assign cs_rise   = cs_q[1] & ~cs_q[2];
  assign cs_fall   = ~cs_q[1] & cs_q[2];
  assign cs_low    = ~cs_q[1];

  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    vld_d = cs_rise && (cnt_q == CNT_FULL);
    if (cs_fall) begin
      cnt_d = '0;
    end else if (sclk_rise && cs_low) begin
      sh_d = {sh_q[FRAME_W-2:0], sdi_q[1]};
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= '1;
      sdi_q  <= '0;
      cnt_q  <= '0;
      sh_q   <= '0;
      vld_q  <= 1'b0;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk};
      cs_q   <= {cs_q[1:0], cs_n};
      sdi_q  <= {sdi_q[0], sdi};
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      vld_q  <= vld_d;
    end
  end

  assign frame_vld  = vld_q;
  assign frame_data = sh_q;
endmodule

// File: rtl/dds_regfile.sv
module dds_regfile
  import dds_pkg::*;
#(
  parameter int ACC_W = dds_pkg::ACC_W,
  parameter int PH_W  = dds_pkg::PH_W
) (
  input  logic             mclk,
  input  logic             rst_n,
  input  logic             frame_vld,
  input  logic [15:0]      frame_data,
  output ctrl_t            ctrl,
  output logic [ACC_W-1:0] freq0,
  output logic [ACC_W-1:0] freq1,
  output logic [PH_W-1:0]  ph0,
  output logic [PH_W-1:0]  ph1
);
  localparam int HW = ACC_W / 2;

  ctrl_t ctrl_q, ctrl_d;
  logic [ACC_W-1:0] fw_q [2];
  logic [ACC_W-1:0] fw_d [2];
  logic [PH_W-1:0]  po_q [2];
  logic [PH_W-1:0]  po_d [2];
  logic [HW-1:0]    lo_q, lo_d;
  logic             pend_q, pend_d, pend_sel_q, pend_sel_d;
  logic [1:0]       tgt;
  logic             fsel_w;
  logic [HW-1:0]    fdat;

  assign tgt    = frame_data[15:14];
  assign fsel_w = frame_data[15];
  assign fdat   = frame_data[HW-1:0];

  always_comb begin
    ctrl_d     = ctrl_q;
    fw_d       = fw_q;
    po_d       = po_q;
    lo_d       = lo_q;
    pend_d     = pend_q;
    pend_sel_d = pend_sel_q;
    if (frame_vld) begin
      unique case (tgt)
        2'b00: begin
          ctrl_d = '{pair_mode: frame_data[13], upper_sel: frame_data[12],
                     fsel: frame_data[11], psel: frame_data[10],
                     hold: frame_data[8], sq_en: frame_data[5],
                     sq_undiv: frame_data[3], tri_mode: frame_data[1]};
          pend_d = 1'b0;
        end
        2'b01, 2'b10: begin
          if (ctrl_q.pair_mode) begin
            if (pend_q && (pend_sel_q == fsel_w)) begin
              fw_d[fsel_w] = {fdat, lo_q};
              pend_d       = 1'b0;
            end else begin
              lo_d       = fdat;
              pend_d     = 1'b1;
              pend_sel_d = fsel_w;
            end
          end else begin
            pend_d = 1'b0;
            if (ctrl_q.upper_sel) fw_d[fsel_w][ACC_W-1:HW] = fdat;
            else                  fw_d[fsel_w][HW-1:0]     = fdat;
          end
        end
        default: po_d[frame_data[13]] = frame_data[PH_W-1:0];
      endcase
    end
  end

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= CTRL_RESET;
      fw_q[0]    <= '0;
      fw_q[1]    <= '0;
      po_q[0]    <= '0;
      po_q[1]    <= '0;
      lo_q       <= '0;
      pend_q     <= 1'b0;
      pend_sel_q <= 1'b0;
    end else begin
      ctrl_q     <= ctrl_d;
      fw_q       <= fw_d;
      po_q       <= po_d;
      lo_q       <= lo_d;
      pend_q     <= pend_d;
      pend_sel_q <= pend_sel_d;
    end
  end

  logic unused_frame;
  assign unused_frame = ^{frame_data[9], frame_data[7:6], frame_data[4],
                          frame_data[2], frame_data[0]};

  assign ctrl  = ctrl_q;
  assign freq0 = fw_q[0];
  assign freq1 = fw_q[1];
  assign ph0   = po_q[0];
  assign ph1   = po_q[1];
endmodule

// File: rtl/dds_core.sv
module dds_core #(
  parameter int ACC_W  = dds_pkg::ACC_W,
  parameter int PH_W   = dds_pkg::PH_W,
  parameter int OUT_W  = dds_pkg::OUT_W
) (
  input  logic             mclk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             fsel,
  input  logic             psel,
  input  logic             tri_mode,
  input  logic             sq_en,
  input  logic             sq_undiv,
  input  logic [ACC_W-1:0] freq0,
  input  logic [ACC_W-1:0] freq1,
  input  logic [PH_W-1:0]  ph0,
  input  logic [PH_W-1:0]  ph1,
  output logic [OUT_W-1:0] wave_out,
  output logic             sq_out,
  output logic [ACC_W-1:0] acc
);
  localparam int AMP_W  = OUT_W - 1;
  localparam int LUT_AW = PH_W - 4;
  localparam int LUT_N  = 1 << LUT_AW;
  localparam int SHIFT  = 2 * LUT_AW - AMP_W;

  function automatic logic [AMP_W-1:0] quarter_amp(input int i);
    int v;
    v = (i * (2 * LUT_N - i)) >>> SHIFT;
    return v[AMP_W-1:0];
  endfunction

  logic [AMP_W-1:0] rom [LUT_N];
  for (genvar g = 0; g < LUT_N; g++) begin : g_rom
    assign rom[g] = quarter_amp(g);
  end

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [OUT_W-1:0] wave_q, wave_d;
  logic             msb_q, half_q, half_d, sq_q, sq_d;
  logic [PH_W-1:0]  pv;
  logic [LUT_AW-1:0] idx;
  logic [AMP_W-1:0] amp, tri_u;
  logic [OUT_W:0]   tri_full;

  assign pv       = acc_q[ACC_W-1 -: PH_W] + (psel ? ph1 : ph0);
  assign idx      = pv[PH_W-2] ? ~pv[PH_W-3 -: LUT_AW] : pv[PH_W-3 -: LUT_AW];
  assign amp      = rom[idx];
  assign tri_u    = pv[PH_W-1] ? ~pv[PH_W-2 -: AMP_W] : pv[PH_W-2 -: AMP_W];
  assign tri_full = {1'b0, tri_u, 1'b0} - (OUT_W+1)'((1 << AMP_W) - 1);

  always_comb begin
    acc_d  = hold ? '0 : acc_q + (fsel ? freq1 : freq0);
    if (tri_mode)        wave_d = tri_full[OUT_W-1:0];
    else if (pv[PH_W-1]) wave_d = -{1'b0, amp};
    else                 wave_d = {1'b0, amp};
    half_d = hold ? 1'b0 : (half_q ^ (acc_q[ACC_W-1] & ~msb_q));
    sq_d   = sq_en & (sq_undiv ? acc_q[ACC_W-1] : half_q);
  end

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      wave_q <= '0;
      msb_q  <= 1'b0;
      half_q <= 1'b0;
      sq_q   <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      wave_q <= wave_d;
      msb_q  <= acc_q[ACC_W-1];
      half_q <= half_d;
      sq_q   <= sq_d;
    end
  end

  logic unused_bits;
  assign unused_bits = ^{pv[1:0], tri_full[OUT_W]};

  assign wave_out = wave_q;
  assign sq_out   = sq_q;
  assign acc      = acc_q;
endmodule

// File: rtl/dds_serial_synth.sv
module dds_serial_synth
  import dds_pkg::*;
(
  input  logic             mclk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             sdi,
  output logic [OUT_W-1:0] wave_out,
  output logic             sq_out
);
  logic               frame_vld;
  logic [FRAME_W-1:0] frame_data;
  ctrl_t              ctrl;
  logic [ACC_W-1:0]   freq0, freq1, acc;
  logic [PH_W-1:0]    ph0, ph1;

  dds_serial_rx #(.FRAME_W(FRAME_W)) rx_i (
    .mclk(mclk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .frame_vld(frame_vld), .frame_data(frame_data)
  );

  dds_regfile #(.ACC_W(ACC_W), .PH_W(PH_W)) regs_i (
    .mclk(mclk), .rst_n(rst_n), .frame_vld(frame_vld), .frame_data(frame_data),
    .ctrl(ctrl), .freq0(freq0), .freq1(freq1), .ph0(ph0), .ph1(ph1)
  );

  dds_core #(.ACC_W(ACC_W), .PH_W(PH_W), .OUT_W(OUT_W)) core_i (
    .mclk(mclk), .rst_n(rst_n), .hold(ctrl.hold), .fsel(ctrl.fsel),
    .psel(ctrl.psel), .tri_mode(ctrl.tri_mode), .sq_en(ctrl.sq_en),
    .sq_undiv(ctrl.sq_undiv), .freq0(freq0), .freq1(freq1), .ph0(ph0),
    .ph1(ph1), .wave_out(wave_out), .sq_out(sq_out), .acc(acc)
  );
endmodule

// File: rtl/dds_serial_synth_chk.sv
module dds_serial_synth_chk
  import dds_pkg::*;
(
  input logic             mclk,
  input logic             rst_n,
  input logic             frame_vld,
  input ctrl_t            ctrl,
  input logic [ACC_W-1:0] acc,
  input logic [ACC_W-1:0] freq0,
  input logic [ACC_W-1:0] freq1,
  input logic [PH_W-1:0]  ph0,
  input logic [PH_W-1:0]  ph1,
  input logic [OUT_W-1:0] wave_out,
  input logic             sq_out
);
  AST_HOLD_ZERO: assert property (@(posedge mclk) disable iff (!rst_n)
    ctrl.hold |=> (acc == '0)); // R8

  AST_SQ_OFF: assert property (@(posedge mclk) disable iff (!rst_n)
    !ctrl.sq_en |=> !sq_out); // R11

  AST_FREQ_COMMIT: assert property (@(posedge mclk) disable iff (!rst_n)
    !frame_vld |=> ($stable(freq0) && $stable(freq1))); // R4

  AST_PHASE_COMMIT: assert property (@(posedge mclk) disable iff (!rst_n)
    !frame_vld |=> ($stable(ph0) && $stable(ph1))); // R3

  AST_WAVE_RANGE: assert property (@(posedge mclk) disable iff (!rst_n)
    wave_out != {1'b1, {(OUT_W-1){1'b0}}}); // R9
endmodule

bind dds_serial_synth dds_serial_synth_chk chk_i (
  .mclk(mclk), .rst_n(rst_n), .frame_vld(frame_vld), .ctrl(ctrl), .acc(acc),
  .freq0(freq0), .freq1(freq1), .ph0(ph0), .ph1(ph1),
  .wave_out(wave_out), .sq_out(sq_out)
);

// File: tb/dds_serial_synth_tb.sv
module dds_serial_synth_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  logic mclk, rst_n, sclk, cs_n, sdi;
  logic [9:0] wave_out;
  logic sq_out;
  int n_run = 0, n_fail = 0, cycles = 0;

  // {triangle, phase offset, expected code}
  localparam logic [22:0] VEC [NVEC] = '{
    {1'b0, 12'h000, 10'h000}, {1'b0, 12'h400, 10'h1FF},
    {1'b0, 12'h200, 10'h180}, {1'b0, 12'hC00, 10'h201},
    {1'b0, 12'h800, 10'h000}, {1'b0, 12'h0FF, 10'h0DC},
    {1'b0, 12'hA00, 10'h280}, {1'b0, 12'h600, 10'h17D},
    {1'b1, 12'h000, 10'h201}, {1'b1, 12'h7FC, 10'h1FF},
    {1'b1, 12'h800, 10'h1FF}, {1'b1, 12'h400, 10'h001},
    {1'b1, 12'hC00, 10'h3FF}, {1'b1, 12'hFFF, 10'h201}
  };

  dds_serial_synth dut_i (
    .mclk(mclk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .wave_out(wave_out), .sq_out(sq_out)
  );

  initial begin
    mclk = 1'b0;
    forever #(CLK_PERIOD / 2) mclk = ~mclk;
  end

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge mclk) begin
    cycles++;
    if (cycles > 150000) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      report();
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [31:0] w, input int nbits);
    @(negedge mclk);
    cs_n = 1'b0;
    repeat (4) @(negedge mclk);
    for (int i = nbits - 1; i >= 0; i--) begin
      sdi = w[i];
      repeat (4) @(negedge mclk);
      sclk = 1'b1;
      repeat (4) @(negedge mclk);
      sclk = 1'b0;
    end
    repeat (4) @(negedge mclk);
    cs_n = 1'b1;
    repeat (12) @(negedge mclk);
  endtask

  task automatic frame(input logic [15:0] w);
    send_bits({16'h0, w}, 16);
  endtask

  task automatic measure(output int per);
    int t = 0;
    int c = 0;
    per = -1;
    while (sq_out && t < 3000) begin @(negedge mclk); t++; end
    while (!sq_out && t < 3000) begin @(negedge mclk); t++; end
    while (sq_out && c < 3000) begin @(negedge mclk); c++; end
    while (!sq_out && c < 3000) begin @(negedge mclk); c++; end
    if (t < 3000 && c < 3000) per = c;
  endtask

  task automatic check_sq_low(input string req, input int len);
    int highs = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge mclk);
      if (sq_out) highs++;
    end
    check(req, highs, 0);
  endtask

  initial begin
    int per;
    sclk = 1'b0; cs_n = 1'b1; sdi = 1'b0; rst_n = 1'b0;
    repeat (5) @(negedge mclk);
    check("R1 wave in reset", int'(wave_out), 0);
    check("R1 sq in reset", int'(sq_out), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge mclk);

    // R9 / R10: zero tuning word, phase value equals phase offset 0
    for (int v = 0; v < NVEC; v++) begin
      frame(16'hC000 | 16'(VEC[v][21:10]));
      frame({14'h0, VEC[v][22], 1'b0});
      check(VEC[v][22] ? "R10 triangle code" : "R9 sine code",
            int'(wave_out), int'(VEC[v][9:0]));
    end

    // R7: phase offset selection
    frame(16'hC400);
    frame(16'hE200);
    frame(16'h0400);
    check("R7 psel=1 uses phase 1", int'(wave_out), 384);
    frame(16'h0000);
    check("R7 psel=0 uses phase 0", int'(wave_out), 511);

    // R2: frames of wrong length are dropped
    send_bits(32'h6000, 15);
    check("R2 15-bit frame ignored", int'(wave_out), 511);
    send_bits(32'h1C000, 17);
    check("R2 17-bit frame ignored", int'(wave_out), 511);

    // R5: direct upper-half write, then R6 / R11 periods
    frame(16'h1028);
    frame(16'h4040);
    frame(16'h0028);
    measure(per);
    check("R5 upper half write, R6 period", per, 256);
    frame(16'h0020);
    measure(per);
    check("R11 divided square period", per, 512);

    // R6: tuning word 1 selection
    frame(16'h1028);
    frame(16'h8080);
    frame(16'h0828);
    measure(per);
    check("R6 fsel=1 period", per, 128);
    frame(16'h0028);
    measure(per);
    check("R6 fsel=0 period", per, 256);

    // R4: paired load
    frame(16'h2028);
    frame(16'h4000);
    frame(16'h4020);
    measure(per);
    check("R4 pair load period", per, 512);
    frame(16'h4040);
    measure(per);
    check("R4 lone first half no effect", per, 512);
    frame(16'h2028);
    frame(16'h4000);
    frame(16'h4080);
    measure(per);
    check("R4 control write clears pending pair", per, 128);

    // R8: hold
    frame(16'h0128);
    repeat (4) @(negedge mclk);
    check_sq_low("R8 square low while held", 600);
    check("R8 wave constant while held", int'(wave_out), 511);

    // R11: square disabled
    frame(16'h0008);
    check_sq_low("R11 square off when disabled", 600);

    // R1: reset during operation
    frame(16'h0028);
    repeat (100) @(negedge mclk);
    rst_n = 1'b0;
    @(negedge mclk);
    check("R1 wave after mid-run reset", int'(wave_out), 0);
    check("R1 sq after mid-run reset", int'(sq_out), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge mclk);
    report();
  end
endmodule